// File: doc/BRIEF.md
# Page Write Commit and Protection Unit

This unit sits between a two-wire serial slave engine and a byte-wide non-volatile array. The engine hands it the word address of each write transaction, then a stream of data bytes, then a STOP strobe. The unit decides whether each item may be acknowledged, gathers the data bytes of one page, and runs a self-timed programming cycle that starts at STOP. Only the bytes actually received in that transaction reach the array.

Two protection mechanisms guard the array. A write-protect pin, when high, refuses every data byte and so blocks all programming. A software protect flag can be set exactly once, through a write whose device-type selector picks the flag instead of the array. After that, the lower half of the array can never be programmed again, and the flag itself is no longer reachable.

Data bytes arrive on a valid/ready stream. `dat_ready` is low for the whole programming cycle, so the engine must hold a byte until it is taken. A byte counts as transferred only in a cycle where `dat_valid` and `dat_ready` are both high, and `ack_allow` in that same cycle gives its acknowledge decision. The command and STOP strobes are single-cycle pulses with no handshake. While the unit is busy they are ignored and `ack_allow` stays low.

Top module: `page_commit_guard`

## Requirements
- R1: After reset, `busy`, `mem_we` and `ack_allow` are low and `dat_ready` is high. The protect flag is clear, so a write to address 0x00 is accepted.
- R2: An array command (`cmd_prot`=0) taken while idle is acknowledged, and its data bytes are acknowledged. A STOP after at least one accepted byte raises `busy` on the next clock edge. `busy` then stays high for exactly PROG_CYCLES cycles.
- R3: During programming, each slot of the page that received a byte is written once to the array, at the page base plus the slot index, in ascending slot order. Slots that received no byte produce no array write.
- R4: Only the low log2(PAGE_BYTES) address bits advance after each accepted byte. A byte beyond PAGE_BYTES wraps to the start of the same page, and the later byte replaces the earlier one in that slot.
- R5: With `wp_pin` high, an array command is still acknowledged. Every data byte of that transaction is refused, and its STOP starts no programming cycle.
- R6: A command with `cmd_prot`=1 while the flag is clear is acknowledged, whatever its address or data value. Its data byte is acknowledged, its STOP starts a programming cycle that writes nothing to the array, and the flag is set when that cycle ends.
- R7: Once the flag is set, a command with `cmd_prot`=1 is not acknowledged, and a STOP that follows it starts no cycle.
- R8: Once the flag is set, a data byte whose target address has bit AW-1 equal to 0 is refused. Nothing from that transaction is programmed, including bytes accepted before it. Targets with bit AW-1 equal to 1 remain writable.
- R9: With `wp_pin` high, the data byte of a `cmd_prot`=1 write is refused, no cycle starts, and the flag stays clear.
- R10: A STOP that follows an array command with no accepted data byte (a dummy write that only sets the address) starts no cycle.
- R11: While `busy` is high, `dat_ready` is low and a command pulse gets no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle pulse: a write transaction's word address is present |
| cmd_prot | input | 1 | Device-type selector: 1 targets the protect flag, 0 targets the array |
| cmd_addr | input | AW | Word address of the transaction |
| dat_valid | input | 1 | Data byte valid |
| dat_ready | output | 1 | Data byte can be taken (low while programming) |
| dat_byte | input | 8 | Data byte |
| stop_pulse | input | 1 | One-cycle pulse: bus STOP seen |
| wp_pin | input | 1 | Hardware write-protect, active high |
| ack_allow | output | 1 | Acknowledge decision for the command or byte taken this cycle |
| busy | output | 1 | Programming cycle in progress |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | AW | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
A wrong slot index or page base in the buffer appears as a wrong `mem_addr`, and a missing or stale valid bit as an extra or missing `mem_we`. Both show within the first PAGE_BYTES cycles of `busy`, where a queue of expected writes, built from the requirements, catches them. A protect flag that is lost or set too early changes `ack_allow` on the very next protected command or low-half data byte. Wrong cycle control shows as a `busy` window that is not exactly PROG_CYCLES long, or as `busy` rising on a STOP that should not start a cycle.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_MEM  = 2'd1,
    TX_PROT = 2'd2,
    TX_DEAD = 2'd3
  } txn_e;
endpackage

// File: rtl/pcg_page_buf.sv
module pcg_page_buf #(
  parameter int AW         = 8,
  parameter int PAGE_BYTES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [AW-1:0] clr_addr,
  input  logic          wr,
  input  logic [7:0]    wr_data,
  input  logic [$clog2(PAGE_BYTES)-1:0] rd_idx,
  output logic [7:0]    rd_data,
  output logic          rd_vld,
  output logic [AW-1:0] cur_addr,
  output logic          any_vld
);
  localparam int PW = $clog2(PAGE_BYTES);

  logic [7:0]            slot_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld_q;
  logic [AW-1:0]         addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      addr_q <= '0;
    end else if (clr) begin
      vld_q  <= '0;
      addr_q <= clr_addr;
    end else if (wr) begin
      vld_q[addr_q[PW-1:0]] <= 1'b1;
      addr_q[PW-1:0]        <= addr_q[PW-1:0] + 1'b1;  // wraps inside the page
    end
  end

  always_ff @(posedge clk) begin
    if (wr && !clr) slot_q[addr_q[PW-1:0]] <= wr_data;
  end

  assign rd_data  = slot_q[rd_idx];
  assign rd_vld   = vld_q[rd_idx];
  assign cur_addr = addr_q;
  assign any_vld  = |vld_q;

  p_ptr_wrap_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !clr) |=> (cur_addr[PW-1:0] == PW'($past(cur_addr[PW-1:0]) + 1'b1))
                     && $stable(cur_addr[AW-1:PW]));
endmodule

// File: rtl/pcg_prog_timer.sv
module pcg_prog_timer #(
  parameter int PROG_CYCLES = 1250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output logic [$clog2(PROG_CYCLES+1)-1:0] cnt
);
  localparam int CW = $clog2(PROG_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(PROG_CYCLES - 1);

  assign done = busy && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (done) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
    end
  end

  p_cnt_bound_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= LAST));
endmodule

// File: rtl/page_commit_guard.sv
module page_commit_guard
  import pcg_pkg::*;
#(
  parameter int AW          = 8,
  parameter int PAGE_BYTES  = 16,
  parameter int PROG_CYCLES = 1250000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_prot,
  input  logic [AW-1:0] cmd_addr,
  input  logic          dat_valid,
  output logic          dat_ready,
  input  logic [7:0]    dat_byte,
  input  logic          stop_pulse,
  input  logic          wp_pin,
  output logic          ack_allow,
  output logic          busy,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata
);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int CW = $clog2(PROG_CYCLES + 1);

  txn_e          txn_q;
  logic          flag_q, hit_q, kind_flag_q;
  logic          buf_clr, buf_wr, data_ok, prog_start, tmr_done;
  logic          rd_vld, any_vld;
  logic [7:0]    rd_data;
  logic [AW-1:0] cur_addr;
  logic [CW-1:0] cnt;
  logic [PW-1:0] slot_idx;

  wire cmd_take  = cmd_valid && !busy;
  wire dat_take  = dat_valid && dat_ready;
  wire stop_take = stop_pulse && !busy;
  wire low_half  = !cur_addr[AW-1];

  assign dat_ready = !busy;

  always_comb begin
    ack_allow = 1'b0;
    buf_clr   = 1'b0;
    buf_wr    = 1'b0;
    data_ok   = 1'b0;
    if (cmd_take) begin
      ack_allow = !(cmd_prot && flag_q);
      buf_clr   = !cmd_prot;
    end else if (dat_take) begin
      case (txn_q)
        TX_MEM: begin
          data_ok   = !wp_pin && !(flag_q && low_half);
          ack_allow = data_ok;
          buf_wr    = data_ok;
        end
        TX_PROT: begin
          data_ok   = !wp_pin;
          ack_allow = data_ok;
        end
        default: ;
      endcase
    end
  end

  assign prog_start = stop_take &&
                      (((txn_q == TX_MEM) && any_vld) || ((txn_q == TX_PROT) && hit_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txn_q       <= TX_IDLE;
      flag_q      <= 1'b0;
      hit_q       <= 1'b0;
      kind_flag_q <= 1'b0;
    end else begin
      if (cmd_take) begin
        txn_q <= cmd_prot ? (flag_q ? TX_IDLE : TX_PROT) : TX_MEM;
        hit_q <= 1'b0;
      end else if (dat_take && (txn_q == TX_MEM || txn_q == TX_PROT)) begin
        if (!data_ok)                txn_q <= TX_DEAD;   // poison the transaction
        else if (txn_q == TX_PROT)   hit_q <= 1'b1;
      end else if (stop_take) begin
        txn_q <= TX_IDLE;
        if (prog_start) kind_flag_q <= (txn_q == TX_PROT);
      end
      if (tmr_done && kind_flag_q) flag_q <= 1'b1;
    end
  end

  pcg_page_buf #(.AW(AW), .PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .clr_addr(cmd_addr),
    .wr(buf_wr), .wr_data(dat_byte), .rd_idx(slot_idx),
    .rd_data(rd_data), .rd_vld(rd_vld), .cur_addr(cur_addr), .any_vld(any_vld)
  );

  pcg_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(prog_start),
    .busy(busy), .done(tmr_done), .cnt(cnt)
  );

  // The first PAGE_BYTES cycles of a memory cycle scan the slots in order.
  assign slot_idx  = cnt[PW-1:0];
  assign mem_we    = busy && !kind_flag_q && (cnt < CW'(PAGE_BYTES)) && rd_vld;
  assign mem_addr  = {cur_addr[AW-1:PW], slot_idx};
  assign mem_wdata = rd_data;

  p_busy_from_stop_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_pulse));
  p_wp_nack_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    (dat_take && wp_pin) |-> !ack_allow);
  p_flag_sticky_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |=> flag_q);
  p_lowhalf_guard_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && flag_q) |-> mem_addr[AW-1]);
endmodule

// File: tb/page_commit_guard_bench.sv
module page_commit_guard_bench;
  localparam int AW = 8, PB = 16, PC = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, cmd_prot = 0, dat_valid = 0, stop_pulse = 0, wp_pin = 0;
  logic [AW-1:0] cmd_addr = '0;
  logic [7:0] dat_byte = '0;
  logic dat_ready, ack_allow, busy, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [15:0] exp_q[$];
  logic [7:0] mbuf[PB];
  bit mmask[PB];
  int mbase = 0, mptr = 0;

  always #4 clk = ~clk;

  page_commit_guard #(.AW(AW), .PAGE_BYTES(PB), .PROG_CYCLES(PC)) u_page_commit_guard (
    .clk, .rst_n, .cmd_valid, .cmd_prot, .cmd_addr, .dat_valid, .dat_ready, .dat_byte,
    .stop_pulse, .wp_pin, .ack_allow, .busy, .mem_we, .mem_addr, .mem_wdata);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: every array write must match the head of the queue.
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_q.size() == 0) chk(0, "R3 unexpected array write", {mem_addr, mem_wdata}, 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk({mem_addr, mem_wdata} == e, "R3 array write", {mem_addr, mem_wdata}, e);
      end
    end
  end

  task automatic send_cmd(input bit prot, input int addr, input bit exp_ack, input string tag);
    @(negedge clk);
    cmd_valid = 1; cmd_prot = prot; cmd_addr = AW'(addr);
    #1 chk(ack_allow == exp_ack, tag, ack_allow, exp_ack);
    @(posedge clk); #1 cmd_valid = 0; cmd_prot = 0;
    if (!prot && exp_ack) begin
      mbase = addr & ~(PB - 1); mptr = addr % PB;
      for (int i = 0; i < PB; i++) mmask[i] = 0;
    end
  endtask

  task automatic send_dat(input int b, input bit exp_ack, input bit to_mem, input string tag);
    @(negedge clk);
    dat_valid = 1; dat_byte = 8'(b);
    #1 chk(ack_allow == exp_ack, tag, ack_allow, exp_ack);
    @(posedge clk); #1 dat_valid = 0;
    if (to_mem && exp_ack) begin
      mbuf[mptr] = 8'(b); mmask[mptr] = 1; mptr = (mptr + 1) % PB;
    end
  endtask

  task automatic send_stop(input bit commit);
    if (commit)
      for (int i = 0; i < PB; i++) if (mmask[i]) exp_q.push_back({8'(mbase + i), mbuf[i]});
    @(negedge clk); stop_pulse = 1;
    @(posedge clk); #1 stop_pulse = 0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    forever begin
      @(negedge clk);
      if (!busy) break;
      n++;
    end
  endtask

  task automatic expect_no_busy(input string tag);
    repeat (3) @(negedge clk);
    chk(busy == 0, tag, busy, 0);
  endtask

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && mem_we == 0 && ack_allow == 0, "R1 reset outputs", {busy, mem_we, ack_allow}, 0);
    chk(dat_ready == 1, "R1 ready after reset", dat_ready, 1);

    // R1 / R2: single byte at the lowest address
    send_cmd(0, 8'h00, 1, "R2 array command ack");
    send_dat(8'hA5, 1, 1, "R1 low half writable after reset");
    send_stop(1);
    wait_idle(n);
    chk(n == PC, "R2 busy length", n, PC);

    // R3 partial page, R11 behaviour while busy
    send_cmd(0, 8'h5D, 1, "R3 cmd");
    send_dat(8'h11, 1, 1, "R3 byte0");
    send_dat(8'h22, 1, 1, "R3 byte1");
    send_dat(8'h33, 1, 1, "R3 byte2");
    send_stop(1);
    @(negedge clk);
    chk(busy == 1, "R2 busy after stop", busy, 1);
    chk(dat_ready == 0, "R11 not ready while busy", dat_ready, 0);
    send_cmd(0, 8'h20, 0, "R11 cmd ignored while busy");
    wait_idle(n);

    // R4 wrap: 17 bytes from 0x9E
    send_cmd(0, 8'h9E, 1, "R4 cmd");
    for (int i = 0; i < 17; i++) send_dat(8'h40 + i, 1, 1, "R4 page byte");
    send_stop(1);
    wait_idle(n);
    chk(exp_q.size() == 0, "R4 all page writes seen", exp_q.size(), 0);

    // R5 hardware protect
    wp_pin = 1;
    send_cmd(0, 8'h40, 1, "R5 cmd ack with wp");
    send_dat(8'h77, 0, 0, "R5 data nack with wp");
    send_dat(8'h78, 0, 0, "R5 second data nack");
    send_stop(0);
    expect_no_busy("R5 no cycle with wp");

    // R9 wp blocks protect write
    send_cmd(1, 8'h00, 1, "R9 prot cmd ack");
    send_dat(8'h00, 0, 0, "R9 prot data nack");
    send_stop(0);
    expect_no_busy("R9 no cycle");
    wp_pin = 0;
    send_cmd(0, 8'h05, 1, "R9 cmd");
    send_dat(8'h5A, 1, 1, "R9 flag still clear");
    send_stop(1);
    wait_idle(n);

    // R10 dummy write
    send_cmd(0, 8'h10, 1, "R10 cmd");
    send_stop(0);
    expect_no_busy("R10 no cycle on dummy write");

    // R6 set the protect flag
    send_cmd(1, 8'h33, 1, "R6 prot cmd ack");
    send_dat(8'hC3, 1, 0, "R6 prot data ack");
    send_stop(0);
    @(negedge clk);
    chk(busy == 1, "R6 protect cycle started", busy, 1);
    wait_idle(n);
    chk(n == PC - 1, "R6 protect cycle length", n + 1, PC);

    // R7 flag is write-once
    send_cmd(1, 8'h00, 0, "R7 prot cmd nack after set");
    send_stop(0);
    expect_no_busy("R7 no cycle");

    // R8 lower half locked, earlier bytes dropped
    send_cmd(0, 8'h7E, 1, "R8 cmd");
    send_dat(8'h01, 0, 0, "R8 low-half nack");
    send_stop(0);
    expect_no_busy("R8 no cycle low half");
    send_cmd(0, 8'hC0, 1, "R8 upper cmd");
    send_dat(8'hE1, 1, 1, "R8 upper byte0");
    send_dat(8'hE2, 1, 1, "R8 upper byte1");
    send_stop(1);
    wait_idle(n);
    chk(exp_q.size() == 0, "R8 upper writes seen", exp_q.size(), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule